// File: doc/BRIEF.md
# USB Token Address Filter

This block sits behind a USB token decoder and decides, for every decoded token, whether the device should respond. It holds an 8-bit function address register made of a 7-bit device address and an enable bit. A separate input allows endpoint 0 to answer tokens sent to the default address 0, so the device can take part in enumeration before software has given it an address.

For each token it compares the token's address with the register and checks the default-address path. It then gives a one-cycle accept pulse one clock after the token, together with the token's endpoint number. Endpoint numbers are not stored here. The endpoint field of an accepted token passes straight through to select the endpoint downstream. Software reads and writes the register over a byte-wide port.

Top module: `usb_token_addr_filter`

## Requirements
- R1: While reset is asserted and right after it, the register reads 0x00, `acc_valid` is 0 and `acc_ep` is 0.
- R2: A write with `reg_we` high stores `reg_wdata` on the clock edge. From then on `reg_rdata` returns that byte, with bit 7 as the address enable and bits 6..0 as the function address.
- R3: When the enable bit is 1 and a valid token's address equals bits 6..0, `acc_valid` is 1 in the next cycle and `acc_ep` equals the token's endpoint.
- R4: When the enable bit is 1 and the token address differs from bits 6..0, the token is not accepted unless R6 applies.
- R5: When the enable bit is 0, no token is accepted through the function address. With `ep0_dflt_en` low, no token is accepted at all.
- R6: When `ep0_dflt_en` is 1, a valid token with address 0 and endpoint 0 is accepted in the next cycle with `acc_ep` = 0, whatever the register holds.
- R7: The default path accepts only endpoint 0. A token to address 0 with a nonzero endpoint is rejected unless the enabled function address is 0.
- R8: A token presented in the same cycle as a register write is judged against the old register value. A token in the following cycle is judged against the new value.
- R9: `acc_valid` is 1 for exactly one cycle per accepted token. It is 0 in the cycle after `tok_valid` is low. `acc_ep` is 0 whenever `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ep0_dflt_en | input | 1 | Lets endpoint 0 answer the default address |
| tok_valid | input | 1 | A decoded token is present |
| tok_addr | input | 7 | Token address field |
| tok_ep | input | 4 | Token endpoint field |
| acc_valid | output | 1 | Token accepted (one-cycle pulse) |
| acc_ep | output | 4 | Endpoint of the accepted token |

## Verification
The hardest case to reach is the write-versus-token race of R8. There, a register write and a token arrive in the same cycle, and the token must be judged against the value being replaced. The stimulus puts a write and a token on the same clock, with addresses chosen so that the old and new register values give opposite verdicts. It then sends the same token again on the next cycle. A second delicate corner is a function address of 0 overlapping the default path, for nonzero and zero endpoints. The stimulus programs that value explicitly, then mixes random traffic biased towards the current address and address 0.

// File: rtl/utaf_pkg.sv
package utaf_pkg;
  localparam int unsigned FA_ADDR_W = 7;
  localparam int unsigned TOK_EP_W  = 4;

  // Which path, if any, claimed the token
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_FUNC = 2'd1,
    HIT_DFLT = 2'd2
  } hit_t;
endpackage

// File: rtl/utaf_rst_sync.sv
module utaf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/utaf_fa_reg.sv
module utaf_fa_reg #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned REG_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              fa_en,
  output logic [ADDR_W-1:0] fa_addr
);
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reg_d;

  // next state: clock enable on write strobe
  always_comb begin
    reg_d = reg_q;
    if (we) reg_d = wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) reg_q <= '0;
    else         reg_q <= reg_d;
  end

  assign rdata   = reg_q;
  assign fa_en   = reg_q[REG_W-1];
  assign fa_addr = reg_q[ADDR_W-1:0];
endmodule

// File: rtl/utaf_match.sv
module utaf_match
  import utaf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned EP_W      = 4,
  parameter bit          HAS_DFLT  = 1'b1,
  parameter int unsigned DFLT_ADDR = 0,
  parameter int unsigned DFLT_EP   = 0
) (
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              fa_en,
  input  logic [ADDR_W-1:0] fa_addr,
  input  logic              dflt_en,
  output hit_t              hit
);
  localparam logic [ADDR_W-1:0] DFLT_A = ADDR_W'(DFLT_ADDR);
  localparam logic [EP_W-1:0]   DFLT_E = EP_W'(DFLT_EP);

  logic func_hit;
  logic dflt_hit;

  assign func_hit = tok_valid && fa_en && (tok_addr == fa_addr);

  generate
    if (HAS_DFLT) begin : g_dflt
      assign dflt_hit = tok_valid && dflt_en &&
                        (tok_addr == DFLT_A) && (tok_ep == DFLT_E);
    end else begin : g_no_dflt
      assign dflt_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (func_hit)      hit = HIT_FUNC;
    else if (dflt_hit) hit = HIT_DFLT;
    else               hit = HIT_NONE;
  end
endmodule

// File: rtl/utaf_out_stage.sv
module utaf_out_stage
  import utaf_pkg::*;
#(
  parameter int unsigned EP_W = 4
) (
  input  logic            clk,
  input  logic            srst_n,
  input  hit_t            hit,
  input  logic [EP_W-1:0] tok_ep,
  output logic            acc_valid,
  output logic [EP_W-1:0] acc_ep
);
  logic            acc_d;
  logic [EP_W-1:0] ep_d;

  always_comb begin
    acc_d = (hit != HIT_NONE);
    ep_d  = acc_d ? tok_ep : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      acc_valid <= 1'b0;
      acc_ep    <= '0;
    end else begin
      acc_valid <= acc_d;
      acc_ep    <= ep_d;
    end
  end
endmodule

// File: rtl/usb_token_addr_filter.sv
module usb_token_addr_filter
  import utaf_pkg::*;
#(
  parameter int unsigned ADDR_W = FA_ADDR_W,
  parameter int unsigned EP_W   = TOK_EP_W,
  localparam int unsigned REG_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ep0_dflt_en,
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  output logic              acc_valid,
  output logic [EP_W-1:0]   acc_ep
);
  logic              srst_n;
  logic              fa_en;
  logic [ADDR_W-1:0] fa_addr;
  hit_t              hit;

  utaf_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  utaf_fa_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk     (clk),
    .srst_n  (srst_n),
    .we      (reg_we),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .fa_en   (fa_en),
    .fa_addr (fa_addr)
  );

  utaf_match #(
    .ADDR_W    (ADDR_W),
    .EP_W      (EP_W),
    .HAS_DFLT  (1'b1),
    .DFLT_ADDR (0),
    .DFLT_EP   (0)
  ) u_match (
    .tok_valid (tok_valid),
    .tok_addr  (tok_addr),
    .tok_ep    (tok_ep),
    .fa_en     (fa_en),
    .fa_addr   (fa_addr),
    .dflt_en   (ep0_dflt_en),
    .hit       (hit)
  );

  utaf_out_stage #(.EP_W(EP_W)) u_out (
    .clk       (clk),
    .srst_n    (srst_n),
    .hit       (hit),
    .tok_ep    (tok_ep),
    .acc_valid (acc_valid),
    .acc_ep    (acc_ep)
  );

  // R2: written byte visible after the edge
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!srst_n)
    reg_we |=> reg_rdata == $past(reg_wdata));

  // R3: enabled address match accepts with pass-through endpoint
  a_r3_func_accept: assert property (@(posedge clk) disable iff (!srst_n)
    (tok_valid && reg_rdata[REG_W-1] && tok_addr == reg_rdata[ADDR_W-1:0])
    |=> (acc_valid && acc_ep == $past(tok_ep)));

  // R4: enabled but different address, no default path
  a_r4_mismatch_reject: assert property (@(posedge clk) disable iff (!srst_n)
    (tok_valid && reg_rdata[REG_W-1] && tok_addr != reg_rdata[ADDR_W-1:0] && !ep0_dflt_en)
    |=> !acc_valid);

  // R5: disabled and no default path, silent
  a_r5_silent: assert property (@(posedge clk) disable iff (!srst_n)
    (!reg_rdata[REG_W-1] && !ep0_dflt_en) |=> !acc_valid);

  // R6: default address on endpoint 0
  a_r6_default_ep0: assert property (@(posedge clk) disable iff (!srst_n)
    (tok_valid && ep0_dflt_en && tok_addr == '0 && tok_ep == '0)
    |=> (acc_valid && acc_ep == '0));

  // R7: default path never opens a nonzero endpoint
  a_r7_default_ep_only0: assert property (@(posedge clk) disable iff (!srst_n)
    (tok_valid && !reg_rdata[REG_W-1] && tok_ep != '0) |=> !acc_valid);

  // R9: no token, no pulse, endpoint cleared
  a_r9_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !tok_valid |=> (!acc_valid && acc_ep == '0));
endmodule

// File: tb/tb_usb_token_addr_filter.sv
`timescale 1ns/1ps
module tb_usb_token_addr_filter;
  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       ep0_dflt_en;
  logic       tok_valid;
  logic [6:0] tok_addr;
  logic [3:0] tok_ep;
  logic       acc_valid;
  logic [3:0] acc_ep;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] m_reg;   // reference model of the register

  usb_token_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ep0_dflt_en(ep0_dflt_en), .tok_valid(tok_valid),
    .tok_addr(tok_addr), .tok_ep(tok_ep), .acc_valid(acc_valid), .acc_ep(acc_ep)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one clock: drive at negedge, model, compare at next negedge
  task automatic step(input logic we, input logic [7:0] wd, input logic dflt,
                      input logic tv, input logic [6:0] ta, input logic [3:0] te);
    logic fh, dh, ex_acc;
    logic [3:0] ex_ep;
    string tag;
    reg_we = we; reg_wdata = wd; ep0_dflt_en = dflt;
    tok_valid = tv; tok_addr = ta; tok_ep = te;
    fh = tv && m_reg[7] && (ta == m_reg[6:0]);
    dh = tv && dflt && (ta == 7'd0) && (te == 4'd0);
    ex_acc = fh || dh;
    ex_ep  = ex_acc ? te : 4'd0;
    if (!tv)                    tag = "R9";
    else if (we)                tag = "R8";
    else if (fh)                tag = "R3";
    else if (dh)                tag = "R6";
    else if (dflt && ta == 0)   tag = "R7";
    else if (!m_reg[7])         tag = "R5";
    else                        tag = "R4";
    if (we) m_reg = wd;
    @(negedge clk);
    check_eq(tag, "acc_valid", int'(acc_valid), int'(ex_acc));
    check_eq(tag, "acc_ep", int'(acc_ep), int'(ex_ep));
    check_eq("R2", "reg_rdata", int'(reg_rdata), int'(m_reg));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_wdata = 0; ep0_dflt_en = 0;
    tok_valid = 0; tok_addr = 0; tok_ep = 0; m_reg = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1", "reg_rdata", int'(reg_rdata), 0);
    check_eq("R1", "acc_valid", int'(acc_valid), 0);
    check_eq("R1", "acc_ep", int'(acc_ep), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1", "reg_rdata after release", int'(reg_rdata), 0);

    // R5: disabled register, no default path, address 0 token ignored
    step(0, 0, 0, 1, 7'd0, 4'd0);
    // R6: default path with register still zero
    step(0, 0, 1, 1, 7'd0, 4'd0);
    // R7: default address, nonzero endpoint
    step(0, 0, 1, 1, 7'd0, 4'd2);
    // R2: program enabled address 5
    step(1, 8'h85, 0, 0, 7'd0, 4'd0);
    // R3: match, endpoint 3 passes through
    step(0, 0, 0, 1, 7'd5, 4'd3);
    // R9: single-cycle pulse, idle after
    step(0, 0, 0, 0, 7'd5, 4'd3);
    // R4: mismatch
    step(0, 0, 0, 1, 7'd6, 4'd1);
    // R6: default still works with function address set
    step(0, 0, 1, 1, 7'd0, 4'd0);
    // R8: write disable on same cycle as matching token: old value accepts
    step(1, 8'h05, 0, 1, 7'd5, 4'd7);
    // R5: next cycle new value rejects
    step(0, 0, 0, 1, 7'd5, 4'd7);
    // R8: enable address 9 while token to 9 arrives: old disabled value rejects
    step(1, 8'h89, 0, 1, 7'd9, 4'd4);
    step(0, 0, 0, 1, 7'd9, 4'd4);
    // R7: enabled function address 0 overlaps default path
    step(1, 8'h80, 1, 0, 7'd0, 4'd0);
    step(0, 0, 1, 1, 7'd0, 4'd2);
    step(0, 0, 0, 1, 7'd0, 4'd0);
    // back-to-back accepts
    step(0, 0, 0, 1, 7'd0, 4'd15);
    step(0, 0, 0, 1, 7'd0, 4'd1);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic we, dflt, tv;
      logic [7:0] wd;
      logic [6:0] ta;
      logic [3:0] te;
      we   = ($urandom_range(0, 9) == 0);
      wd   = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) wd[6:0] = 7'($urandom_range(0, 3));
      dflt = 1'($urandom_range(0, 1));
      tv   = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 2))
        0:       ta = m_reg[6:0];
        1:       ta = 7'd0;
        default: ta = 7'($urandom_range(0, 127));
      endcase
      te = ($urandom_range(0, 1) == 1) ? 4'd0 : 4'($urandom_range(0, 15));
      step(we, wd, dflt, tv, ta, te);
    end

    done = 1;
    report();
  end
endmodule